// File: doc/BRIEF.md
# XY-Mesh Routing Fault Checker

This block sits beside the router of one switch in a two-dimensional mesh that routes packets dimension-ordered (first along X, then along Y) with wormhole switching. For every header flit it looks at the switch's own coordinates, the packet's source and destination coordinates, the packet's hop counter and the output port the router picked, and decides whether the control path of the network has misbehaved. It does not compute routes and takes no recovery action. It only raises flags, a drop request and a fault report for a recovery agent to consume.

Three faults are recognised. The first is a packet that sits at a position no legal X-then-Y path could reach. The second is a packet whose 4-bit hop counter is already at its maximum, so one more hop would overflow it. This catches packets that bounce forever between two neighbours along their own legal row, which the position rule cannot see. The third is a packet handed to the local processing port of a switch that is not its destination. A stuck output that happens to equal the correct choice leaves no trace and is not flagged. All results are registered and appear in the cycle after the header flit, as one-cycle pulses.

Top module: `xy_route_checker`

## Requirements
- R1: While reset is low and in the first cycle after it, every output is zero.
- R2: A header flit at a switch whose Y differs from the source Y and whose X differs from the destination X raises `err_deflect` in the next cycle, with report code 2'b01 when it is the only fault.
- R3: A header flit at a switch whose Y equals the source Y, or whose X equals the destination X, raises no position fault. This includes a packet that has bounced back along its source row, and a packet routed correctly by a stuck output.
- R4: In the cycle after a header flit, `hop_out` equals the incoming hop count plus one, modulo 16.
- R5: A header flit whose hop count is 15 raises `err_overflow` and `drop_req` in the next cycle, with report code 2'b10 when no trapped fault is present. `hop_out` then reads 0.
- R6: A header flit steered to output port 0 (the local processing port) whose destination differs from the switch coordinates raises `err_trapped` in the next cycle, with code 2'b11. Output port 0 with a matching destination raises nothing.
- R7: A flit with `flit_valid` low, or with `flit_head` low (a body or tail flit), produces no flag, no drop and no report in the next cycle, and leaves `hop_out` unchanged.
- R8: When any fault is present, `rpt_valid` is high and `rpt_x`/`rpt_y` carry the switch coordinates. If several faults coincide, the code is chosen by priority: trapped (11) over overflow (10) over deflection (01).
- R9: Flags and the report last one cycle per header flit. They are all zero in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_head | input | 1 | The present flit is a header flit |
| my_x | input | COORD_W | X coordinate of this switch |
| my_y | input | COORD_W | Y coordinate of this switch |
| src_x | input | COORD_W | Source X of the packet |
| src_y | input | COORD_W | Source Y of the packet |
| dst_x | input | COORD_W | Destination X of the packet |
| dst_y | input | COORD_W | Destination Y of the packet |
| hop_in | input | HOP_W | Hop count carried by the header |
| out_port | input | PORT_W | Output port chosen by the router, 0 = local |
| err_deflect | output | 1 | Position outside any legal XY path |
| err_overflow | output | 1 | Hop count would overflow |
| err_trapped | output | 1 | Delivered locally to the wrong switch |
| drop_req | output | 1 | Packet must be discarded |
| hop_out | output | HOP_W | Incremented hop count for the header |
| rpt_valid | output | 1 | Fault report present |
| rpt_x | output | COORD_W | Switch X in the report |
| rpt_y | output | COORD_W | Switch Y in the report |
| rpt_code | output | 2 | Fault code |

## Verification
The bench walks a packet along a legal X-then-Y path, including the turn switch and the last switch. A checker that tested the wrong coordinate pair would flag one of these hops. It places a packet that has bounced back along its source row and confirms that only a full hop counter flags it. It also sends hop count 15, where a checker with an off-by-one limit would either drop a packet too early or let the counter wrap. Coincident faults test the code priority. Local delivery is tried both with a matching destination and with a wrong one. Body flits carrying illegal coordinates check that only header flits are examined and that `hop_out` holds its value.

// File: rtl/xyc_pkg.sv
// Package: shared fault codes for the XY routing fault checker.
// Assumes a 2-bit report code. Value 0 means no fault.
package xyc_pkg;
    typedef enum logic [1:0] {
        CODE_NONE     = 2'b00,
        CODE_DEFLECT  = 2'b01,
        CODE_OVERFLOW = 2'b10,
        CODE_TRAPPED  = 2'b11
    } fault_code_e;
endpackage

// File: rtl/xyc_pos_rule.sv
// Position rule: under X-then-Y routing a packet may only be at a switch that
// shares the source row or the destination column. Combinational.
// Assumes coordinates are unsigned and equal width.
module xyc_pos_rule #(
    parameter int COORD_W = 3
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    output logic               stray
);
    // Flag a switch on neither the source row nor the destination column
    always_comb begin
        stray = (here_y != src_y) && (here_x != dst_x);
    end
endmodule

// File: rtl/xyc_hop_stage.sv
// Hop stage: increments the hop counter and reports when the increment
// would pass the largest representable value. Combinational.
// Assumes HOP_W >= 1. The incremented value wraps on overflow.
module xyc_hop_stage #(
    parameter int HOP_W = 4
) (
    input  logic [HOP_W-1:0] hop_in,
    output logic [HOP_W-1:0] hop_next,
    output logic             wrap
);
    localparam logic [HOP_W-1:0] HOP_MAX = {HOP_W{1'b1}};

    // Add one hop and detect the saturating value
    always_comb begin
        hop_next = hop_in + {{(HOP_W-1){1'b0}}, 1'b1};
        wrap     = (hop_in == HOP_MAX);
    end
endmodule

// File: rtl/xyc_trap_rule.sv
// Trap rule: a packet sent to the local processing port must be addressed
// to this switch. Combinational.
// Assumes the local port has encoding LOCAL_PORT.
module xyc_trap_rule #(
    parameter int COORD_W    = 3,
    parameter int PORT_W     = 3,
    parameter int LOCAL_PORT = 0
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [PORT_W-1:0]  out_port,
    output logic               trapped
);
    localparam logic [PORT_W-1:0] LOCAL_SEL = PORT_W'(LOCAL_PORT);

    // Local delivery with a destination that is not this switch
    always_comb begin
        trapped = (out_port == LOCAL_SEL) && ((dst_x != here_x) || (dst_y != here_y));
    end
endmodule

// File: rtl/xy_route_checker.sv
// XY routing fault checker for one mesh switch.
// Examines each header flit (flit_valid & flit_head) and, one cycle later,
// pulses fault flags, a drop request, the incremented hop count and a
// coded fault report. Body flits are ignored. Reset is synchronous, active low.
module xy_route_checker #(
    parameter int COORD_W    = 3,
    parameter int HOP_W      = 4,
    parameter int PORT_W     = 3,
    parameter int LOCAL_PORT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flit_valid,
    input  logic               flit_head,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [HOP_W-1:0]   hop_in,
    input  logic [PORT_W-1:0]  out_port,
    output logic               err_deflect,
    output logic               err_overflow,
    output logic               err_trapped,
    output logic               drop_req,
    output logic [HOP_W-1:0]   hop_out,
    output logic               rpt_valid,
    output logic [COORD_W-1:0] rpt_x,
    output logic [COORD_W-1:0] rpt_y,
    output logic [1:0]         rpt_code
);
    import xyc_pkg::*;

    logic             head_seen;
    logic             stray;
    logic             wrap;
    logic             trapped;
    logic [HOP_W-1:0] hop_next;
    fault_code_e      code_d;
    logic             src_x_unused;

    assign src_x_unused = ^src_x;

    xyc_pos_rule #(.COORD_W(COORD_W)) u_pos (
        .here_x (my_x),
        .here_y (my_y),
        .src_y  (src_y),
        .dst_x  (dst_x),
        .stray  (stray)
    );

    xyc_hop_stage #(.HOP_W(HOP_W)) u_hop (
        .hop_in   (hop_in),
        .hop_next (hop_next),
        .wrap     (wrap)
    );

    xyc_trap_rule #(.COORD_W(COORD_W), .PORT_W(PORT_W), .LOCAL_PORT(LOCAL_PORT)) u_trap (
        .here_x   (my_x),
        .here_y   (my_y),
        .dst_x    (dst_x),
        .dst_y    (dst_y),
        .out_port (out_port),
        .trapped  (trapped)
    );

    // Qualify: only header flits are examined
    always_comb begin
        head_seen = flit_valid && flit_head;
    end

    // Select the report code by priority: trapped, overflow, deflection
    always_comb begin
        if (trapped)     code_d = CODE_TRAPPED;
        else if (wrap)   code_d = CODE_OVERFLOW;
        else if (stray)  code_d = CODE_DEFLECT;
        else             code_d = CODE_NONE;
    end

    // Register one-cycle fault pulses and the report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_deflect  <= 1'b0;
            err_overflow <= 1'b0;
            err_trapped  <= 1'b0;
            drop_req     <= 1'b0;
            rpt_valid    <= 1'b0;
            rpt_x        <= '0;
            rpt_y        <= '0;
            rpt_code     <= 2'b00;
        end else begin
            err_deflect  <= head_seen && stray;
            err_overflow <= head_seen && wrap;
            err_trapped  <= head_seen && trapped;
            drop_req     <= head_seen && wrap;
            rpt_valid    <= head_seen && (code_d != CODE_NONE);
            rpt_x        <= (head_seen && (code_d != CODE_NONE)) ? my_x : '0;
            rpt_y        <= (head_seen && (code_d != CODE_NONE)) ? my_y : '0;
            rpt_code     <= head_seen ? code_d : CODE_NONE;
        end
    end

    // Hold the incremented hop count of the most recent header
    always_ff @(posedge clk) begin
        if (!rst_n)         hop_out <= '0;
        else if (head_seen) hop_out <= hop_next;
    end
endmodule

// File: rtl/xyc_checker.sv
// Checker: temporal properties of the XY routing fault checker, bound to
// every instance of the top module.
module xyc_checker #(
    parameter int COORD_W    = 3,
    parameter int HOP_W      = 4,
    parameter int PORT_W     = 3,
    parameter int LOCAL_PORT = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flit_valid,
    input logic               flit_head,
    input logic [COORD_W-1:0] my_x,
    input logic [COORD_W-1:0] my_y,
    input logic [COORD_W-1:0] src_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [HOP_W-1:0]   hop_in,
    input logic [PORT_W-1:0]  out_port,
    input logic               err_deflect,
    input logic               err_overflow,
    input logic               err_trapped,
    input logic               drop_req,
    input logic [HOP_W-1:0]   hop_out,
    input logic               rpt_valid,
    input logic [COORD_W-1:0] rpt_x,
    input logic [COORD_W-1:0] rpt_y,
    input logic [1:0]         rpt_code
);
    localparam logic [HOP_W-1:0]  HOP_MAX   = {HOP_W{1'b1}};
    localparam logic [PORT_W-1:0] LOCAL_SEL = PORT_W'(LOCAL_PORT);

    AST_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_deflect || err_overflow || err_trapped || drop_req || rpt_valid)
        |-> $past(flit_valid && flit_head)); // R7

    AST_DEFLECT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        err_deflect |-> ($past(my_y) != $past(src_y) && $past(my_x) != $past(dst_x))); // R2

    AST_DROP_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        drop_req |-> ($past(hop_in) == HOP_MAX && err_overflow)); // R5

    AST_TRAP_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_trapped |-> ($past(out_port) == LOCAL_SEL && rpt_code == 2'b11)); // R6

    AST_HOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flit_valid && flit_head) |-> hop_out == HOP_W'($past(hop_in) + 1'b1)); // R4

    AST_RPT_WHERE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_x == $past(my_x) && rpt_y == $past(my_y) && rpt_code != 2'b00)); // R8

    AST_OVF_OVER_DEFL: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overflow && !err_trapped) |-> rpt_code == 2'b10); // R8
endmodule

bind xy_route_checker xyc_checker #(
    .COORD_W(COORD_W), .HOP_W(HOP_W), .PORT_W(PORT_W), .LOCAL_PORT(LOCAL_PORT)
) u_xyc_checker (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
    .my_x(my_x), .my_y(my_y), .src_y(src_y), .dst_x(dst_x), .hop_in(hop_in),
    .out_port(out_port), .err_deflect(err_deflect), .err_overflow(err_overflow),
    .err_trapped(err_trapped), .drop_req(drop_req), .hop_out(hop_out),
    .rpt_valid(rpt_valid), .rpt_x(rpt_x), .rpt_y(rpt_y), .rpt_code(rpt_code)
);

// File: tb/tb_xy_route_checker.sv
// Directed bench for the XY routing fault checker.
module tb_xy_route_checker;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;
    localparam int HW = 4;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flit_valid = 1'b0;
    logic          flit_head = 1'b0;
    logic [CW-1:0] my_x = '0, my_y = '0, src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
    logic [HW-1:0] hop_in = '0;
    logic [PW-1:0] out_port = 3'd1;
    logic          err_deflect, err_overflow, err_trapped, drop_req, rpt_valid;
    logic [HW-1:0] hop_out;
    logic [CW-1:0] rpt_x, rpt_y;
    logic [1:0]    rpt_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xy_route_checker #(.COORD_W(CW), .HOP_W(HW), .PORT_W(PW), .LOCAL_PORT(0)) dut (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_head(flit_head),
        .my_x(my_x), .my_y(my_y), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .hop_in(hop_in), .out_port(out_port), .err_deflect(err_deflect),
        .err_overflow(err_overflow), .err_trapped(err_trapped), .drop_req(drop_req),
        .hop_out(hop_out), .rpt_valid(rpt_valid), .rpt_x(rpt_x), .rpt_y(rpt_y),
        .rpt_code(rpt_code)
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one flit for a cycle; outputs are read at the following negedge
    task automatic send(input int mx, input int my, input int sy, input int dx,
                        input int dy, input int hop, input int port, input bit head);
        @(negedge clk);
        my_x = CW'(mx); my_y = CW'(my); src_x = CW'(mx); src_y = CW'(sy);
        dst_x = CW'(dx); dst_y = CW'(dy); hop_in = HW'(hop); out_port = PW'(port);
        flit_valid = 1'b1; flit_head = head;
        @(negedge clk);
        flit_valid = 1'b0; flit_head = 1'b0;
    endtask

    // Check the whole registered result of the last flit
    task automatic expect_out(input string tag, input int d, input int o, input int t,
                              input int code, input int rx, input int ry, input int hop);
        chk({tag, " err_deflect"},  err_deflect, d);
        chk({tag, " err_overflow"}, err_overflow, o);
        chk({tag, " drop_req"},     drop_req, o);
        chk({tag, " err_trapped"},  err_trapped, t);
        chk({tag, " rpt_valid"},    rpt_valid, (code != 0) ? 1 : 0);
        chk({tag, " rpt_code"},     rpt_code, code);
        chk({tag, " rpt_x"},        rpt_x, rx);
        chk({tag, " rpt_y"},        rpt_y, ry);
        chk({tag, " hop_out"},      hop_out, hop);
    endtask

    // R1: outputs during and right after reset
    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R3: legal path (1,0)->(0,0)->(0,1), ports E/W then N then local
    task automatic t_legal_path();
        send(1, 0, 0, 0, 1, 0, 4, 1'b1);
        expect_out("R3 start hop", 0, 0, 0, 0, 0, 0, 1);
        send(0, 0, 0, 0, 1, 1, 1, 1'b1);
        expect_out("R3 turn hop", 0, 0, 0, 0, 0, 0, 2);
        send(0, 1, 0, 0, 1, 2, 0, 1'b1);
        expect_out("R6 local match", 0, 0, 0, 0, 0, 0, 3);
    endtask

    // R2 and R9: off-path switch, then the pulse must vanish
    task automatic t_deflect();
        send(1, 2, 1, 2, 2, 4, 2, 1'b1);
        expect_out("R2 deflect", 1, 0, 0, 1, 1, 2, 5);
        @(negedge clk);
        expect_out("R9 pulse cleared", 0, 0, 0, 0, 0, 0, 5);
    endtask

    // R3: bounced back along source row is legal by position alone
    task automatic t_bounce();
        send(3, 2, 2, 1, 1, 7, 3, 1'b1);
        expect_out("R3 bounce row", 0, 0, 0, 0, 0, 0, 8);
    endtask

    // R5 and R4: hop counter at maximum
    task automatic t_overflow();
        send(3, 2, 2, 1, 1, 14, 4, 1'b1);
        expect_out("R4 hop 14", 0, 0, 0, 0, 0, 0, 15);
        send(3, 2, 2, 1, 1, 15, 4, 1'b1);
        expect_out("R5 overflow", 0, 1, 0, 2, 3, 2, 0);
    endtask

    // R6: local delivery to the wrong switch
    task automatic t_trapped();
        send(1, 1, 1, 2, 1, 4, 0, 1'b1);
        expect_out("R6 trapped", 0, 0, 1, 3, 1, 1, 5);
    endtask

    // R8: coincident faults follow the priority
    task automatic t_priority();
        send(5, 6, 2, 1, 3, 15, 1, 1'b1);
        expect_out("R8 ovf over deflect", 1, 1, 0, 2, 5, 6, 0);
        send(5, 6, 2, 1, 3, 15, 0, 1'b1);
        expect_out("R8 trap over all", 1, 1, 1, 3, 5, 6, 0);
        send(7, 4, 2, 1, 3, 2, 0, 1'b1);
        expect_out("R8 trap over deflect", 1, 0, 1, 3, 7, 4, 3);
    endtask

    // R7: body flits and invalid flits are not examined
    task automatic t_body();
        send(1, 2, 1, 2, 2, 15, 0, 1'b0);
        expect_out("R7 body flit", 0, 0, 0, 0, 0, 0, 3);
        @(negedge clk);
        my_x = 3'd6; my_y = 3'd6; src_y = 3'd0; dst_x = 3'd1; hop_in = 4'd15;
        out_port = 3'd0; flit_head = 1'b1; flit_valid = 1'b0;
        @(negedge clk);
        flit_head = 1'b0;
        expect_out("R7 invalid head", 0, 0, 0, 0, 0, 0, 3);
    endtask

    initial begin
        t_reset();
        t_legal_path();
        t_deflect();
        t_bounce();
        t_overflow();
        t_trapped();
        t_priority();
        t_body();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule